// File: doc/BRIEF.md
# Serial Memory Slave Front End

This block is the serial side of a 512-byte non-volatile memory. An SPI master in mode 0 selects it with an active-low chip select, shifts 8-bit commands and addresses in on the data input, and reads bytes back on the data output. The data output has a separate enable, so several devices can share the bus. The SPI lines are oversampled by a faster system clock through two-flop synchronizers. All bit and byte sequencing is done in the system clock domain.

The ninth address bit travels inside the command byte, and a lower address byte follows it. Reads stream bytes and move across the whole 512-byte space. Writes collect up to a page of bytes in a 16-entry latch and wrap inside that page. The collected bytes are handed to a store unit as one commit request, and only when the select line is released on a byte boundary. The store unit holds a write-enable flag and a two-bit protection level. It also models a busy period of `WR_CYCLES` system clocks, and during that period everything except a status read is refused. A hold input can pause a transfer in the middle without losing its place.

Top module: `serial_mem_slave`

## Requirements
- R1: After reset, and whenever chip select is high, `so_oe` is 0. A reset leaves the status byte at 0x00 and every array byte at 0x00.
- R2: Commands are 8 bits, sent MSB first, sampled on SCK rising edges. A read is `0000_A011` and a write is `0000_A010`, with A (bit 3) as address bit 8. A lower address byte follows. The addressed byte then appears on `so`, MSB first, changing after SCK falling edges.
- R3: A read continues with the next address after each byte and wraps from 0x1FF to 0x000 for as long as chip select stays low.
- R4: Opcode 0x06 sets the write-enable flag and 0x04 clears it. Each takes effect when chip select rises right after the eighth bit. Opcode 0x05 returns the status byte, repeated while clocks continue. The status byte is {4'b0, level[1:0], enable flag, busy}, with busy at bit 0 and the enable flag at bit 1.
- R5: A write takes any number of data bytes. The low 4 address bits count up and wrap from 15 to 0 inside the page, so later bytes overwrite earlier ones at the same offset.
- R6: A write is committed only if chip select rises after a complete data byte. A rise after a partial byte, or before any data byte, leaves the array unchanged and keeps the enable flag.
- R7: A commit needs the enable flag set. An accepted commit clears the flag, sets busy for `WR_CYCLES` system clocks and then clears busy. Without the flag, nothing happens.
- R8: While busy, every command except 0x05 is ignored until chip select goes high: no data is driven on a read, and 0x06 does not set the flag. A status read works and shows busy.
- R9: Opcode 0x01 followed by one byte sets the protection level from bits 3:2 of that byte, committed as in R6 and R7. A level of 1 blocks 0x180–0x1FF, 2 blocks 0x100–0x1FF, and 3 blocks everything. A blocked write changes nothing and leaves the flag set and busy clear.
- R10: When HOLD goes low while SCK is low, the transfer pauses, SCK and SI are ignored and `so_oe` is 0. HOLD going high while SCK is low resumes the transfer exactly where it stopped.
- R11: When HOLD goes low while SCK is high, the bit in progress completes on the next SCK fall, and then the transfer pauses as in R10.
- R12: Any other opcode is ignored until chip select goes high, with `so_oe` held at 0 and no change to state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the master (mode 0) |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data into the block |
| hold_n | input | 1 | Active-low pause request |
| so | output | 1 | Serial data out of the block |
| so_oe | output | 1 | Output enable for `so`; 0 means high impedance |

## Verification
A wrong bit counter or sequencer state shows within one byte as a shifted or missing read byte, or as an output enable raised at the wrong moment. A wrong address counter shows within two bytes of a read, once the transfer crosses a page or the top of the array. A wrong commit or enable-flag decision in the store is hidden until the next status read or read-back. So the bench follows every write with a status read and a full read-back of the page it touched. A hold that resumes in the wrong place corrupts the very next byte on the bus.

// File: rtl/spimem_pkg.sv
package spimem_pkg;
    localparam int ADDR_W     = 9;
    localparam int PAGE_W     = 4;
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int MEM_BYTES  = 1 << ADDR_W;
    localparam int PAGE_NUM_W = ADDR_W - PAGE_W;

    // low three bits of the array opcodes; bit 3 carries the top address bit
    localparam logic [2:0] OPL_READ  = 3'b011;
    localparam logic [2:0] OPL_WRITE = 3'b010;
    localparam logic [7:0] OP_FLAG_SET = 8'h06;
    localparam logic [7:0] OP_FLAG_CLR = 8'h04;
    localparam logic [7:0] OP_STAT_RD  = 8'h05;
    localparam logic [7:0] OP_STAT_WR  = 8'h01;

    typedef enum logic [2:0] {
        S_OPC, S_ADDR, S_RDATA, S_WDATA, S_SRRD, S_SRWR, S_ARMED, S_IGNORE
    } seq_state_e;

    typedef enum logic [1:0] {
        ARM_FLAG_SET, ARM_FLAG_CLR, ARM_STAT_WR
    } arm_kind_e;
endpackage

// File: rtl/spimem_sync.sv
module spimem_sync #(
    parameter int          N       = 4,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    logic [N-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= RST_VAL;
        else        stg_q[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= RST_VAL;
            else        stg_q[s] <= stg_q[s-1];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/spimem_seq.sv
module spimem_seq
    import spimem_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sck_s,
    input  logic                  cs_n_s,
    input  logic                  si_s,
    input  logic                  hold_n_s,
    input  logic                  busy_i,
    input  logic [7:0]            status_i,
    input  logic [7:0]            rd_data_i,
    output logic [ADDR_W-1:0]     rd_addr_o,
    output logic                  lat_clr_o,
    output logic                  lat_we_o,
    output logic [PAGE_W-1:0]     lat_idx_o,
    output logic [7:0]            lat_data_o,
    output logic                  arr_commit_o,
    output logic [PAGE_NUM_W-1:0] commit_page_o,
    output logic                  sr_commit_o,
    output logic [1:0]            sr_bp_o,
    output logic                  wel_set_o,
    output logic                  wel_clr_o,
    output logic                  so_o,
    output logic                  so_oe_o
);
    typedef struct packed {
        seq_state_e        state;
        arm_kind_e         arm;
        logic [2:0]        bit_cnt;
        logic [6:0]        in_sh;
        logic [7:0]        out_sh;
        logic              oe;
        logic              is_wr;
        logic              a8;
        logic [ADDR_W-1:0] addr;
        logic              got_data;
        logic [1:0]        sr_bp;
        logic              paused;
        logic              sck_prev;
        logic              cs_prev;
    } seq_t;

    localparam seq_t SEQ_RST = '{state: S_OPC, arm: ARM_FLAG_SET, bit_cnt: '0,
                                 in_sh: '0, out_sh: '0, oe: 1'b0, is_wr: 1'b0,
                                 a8: 1'b0, addr: '0, got_data: 1'b0, sr_bp: '0,
                                 paused: 1'b0, sck_prev: 1'b0, cs_prev: 1'b1};

    seq_t q_q, q_d;
    logic sck_rise, sck_fall, cs_rise, rise_ev, fall_ev;
    logic [7:0] rx_byte;

    always_comb begin
        q_d           = q_q;
        lat_clr_o     = 1'b0;
        lat_we_o      = 1'b0;
        arr_commit_o  = 1'b0;
        sr_commit_o   = 1'b0;
        wel_set_o     = 1'b0;
        wel_clr_o     = 1'b0;

        sck_rise = sck_s & ~q_q.sck_prev;
        sck_fall = ~sck_s & q_q.sck_prev;
        cs_rise  = cs_n_s & ~q_q.cs_prev;
        rise_ev  = sck_rise & ~q_q.paused & ~cs_n_s;
        fall_ev  = sck_fall & ~q_q.paused & ~cs_n_s;
        rx_byte  = {q_q.in_sh, si_s};

        q_d.sck_prev = sck_s;
        q_d.cs_prev  = cs_n_s;

        // pause enters and leaves only while the serial clock is low
        if (q_q.paused) q_d.paused = ~(hold_n_s & ~sck_s);
        else            q_d.paused = ~hold_n_s & ~sck_s;

        if (cs_rise && q_q.bit_cnt == 3'd0) begin
            if (q_q.state == S_WDATA && q_q.got_data) arr_commit_o = 1'b1;
            if (q_q.state == S_ARMED) begin
                case (q_q.arm)
                    ARM_FLAG_SET: wel_set_o   = 1'b1;
                    ARM_FLAG_CLR: wel_clr_o   = 1'b1;
                    default:      sr_commit_o = 1'b1;
                endcase
            end
        end

        if (cs_n_s) begin
            q_d.state    = S_OPC;
            q_d.bit_cnt  = '0;
            q_d.oe       = 1'b0;
            q_d.paused   = 1'b0;
            q_d.got_data = 1'b0;
        end else begin
            if (rise_ev) begin
                q_d.bit_cnt = q_q.bit_cnt + 3'd1;
                q_d.in_sh   = rx_byte[6:0];
                if (q_q.state == S_ARMED) q_d.state = S_IGNORE;
                if (q_q.bit_cnt == 3'd7) begin
                    case (q_q.state)
                        S_OPC: begin
                            q_d.a8 = rx_byte[3];
                            if (busy_i && rx_byte != OP_STAT_RD) begin
                                q_d.state = S_IGNORE;
                            end else if (rx_byte[7:4] == 4'h0 && rx_byte[2:0] == OPL_READ) begin
                                q_d.state = S_ADDR;
                                q_d.is_wr = 1'b0;
                            end else if (rx_byte[7:4] == 4'h0 && rx_byte[2:0] == OPL_WRITE) begin
                                q_d.state = S_ADDR;
                                q_d.is_wr = 1'b1;
                            end else begin
                                case (rx_byte)
                                    OP_FLAG_SET: begin q_d.state = S_ARMED; q_d.arm = ARM_FLAG_SET; end
                                    OP_FLAG_CLR: begin q_d.state = S_ARMED; q_d.arm = ARM_FLAG_CLR; end
                                    OP_STAT_RD:  q_d.state = S_SRRD;
                                    OP_STAT_WR:  q_d.state = S_SRWR;
                                    default:     q_d.state = S_IGNORE;
                                endcase
                            end
                        end
                        S_ADDR: begin
                            q_d.addr  = {q_q.a8, rx_byte};
                            q_d.state = q_q.is_wr ? S_WDATA : S_RDATA;
                            lat_clr_o = q_q.is_wr;
                        end
                        S_WDATA: begin
                            lat_we_o = 1'b1;
                            q_d.got_data = 1'b1;
                            q_d.addr[PAGE_W-1:0] = q_q.addr[PAGE_W-1:0] + 1'b1;
                        end
                        S_SRWR: begin
                            q_d.sr_bp = rx_byte[3:2];
                            q_d.state = S_ARMED;
                            q_d.arm   = ARM_STAT_WR;
                        end
                        default: ;
                    endcase
                end
            end
            if (fall_ev && (q_q.state == S_RDATA || q_q.state == S_SRRD)) begin
                if (q_q.bit_cnt == 3'd0) begin
                    q_d.oe = 1'b1;
                    if (q_q.state == S_RDATA) begin
                        q_d.out_sh = rd_data_i;
                        q_d.addr   = q_q.addr + 1'b1;
                    end else begin
                        q_d.out_sh = status_i;
                    end
                end else begin
                    q_d.out_sh = {q_q.out_sh[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= SEQ_RST;
        else        q_q <= q_d;
    end

    assign rd_addr_o     = q_q.addr;
    assign lat_idx_o     = q_q.addr[PAGE_W-1:0];
    assign lat_data_o    = rx_byte;
    assign commit_page_o = q_q.addr[ADDR_W-1:PAGE_W];
    assign sr_bp_o       = q_q.sr_bp;
    assign so_o          = q_q.out_sh[7];
    assign so_oe_o       = q_q.oe & ~q_q.paused & hold_n_s;

    a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !q_q.oe);
    a_r10_pause_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.paused && !cs_n_s) |=> $stable(q_q.bit_cnt) && $stable(q_q.addr));
    a_r8_busy_no_array: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> !(q_q.state inside {S_RDATA, S_WDATA}));
    a_r12_drive_only_reads: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.oe |-> (q_q.state inside {S_RDATA, S_SRRD}));
endmodule

// File: rtl/spimem_store.sv
module spimem_store
    import spimem_pkg::*;
#(
    parameter int WR_CYCLES = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     rd_addr_i,
    output logic [7:0]            rd_data_o,
    input  logic                  lat_clr_i,
    input  logic                  lat_we_i,
    input  logic [PAGE_W-1:0]     lat_idx_i,
    input  logic [7:0]            lat_data_i,
    input  logic                  arr_commit_i,
    input  logic [PAGE_NUM_W-1:0] commit_page_i,
    input  logic                  sr_commit_i,
    input  logic [1:0]            sr_bp_i,
    input  logic                  wel_set_i,
    input  logic                  wel_clr_i,
    output logic [7:0]            status_o,
    output logic                  busy_o
);
    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    typedef struct packed {
        logic                  wel;
        logic                  busy;
        logic [CNT_W-1:0]      cnt;
        logic [1:0]            bp;
        logic [PAGE_BYTES-1:0] mask;
    } store_t;

    store_t q_q, q_d;
    logic [7:0] lat_q [PAGE_BYTES];
    logic [7:0] mem_q [MEM_BYTES];
    logic prot_hit, arr_ok, sr_ok;

    function automatic logic page_blocked(input logic [1:0] lvl,
                                          input logic [PAGE_NUM_W-1:0] pg);
        case (lvl)
            2'd0:    return 1'b0;
            2'd1:    return pg[PAGE_NUM_W-1 -: 2] == 2'b11;
            2'd2:    return pg[PAGE_NUM_W-1];
            default: return 1'b1;
        endcase
    endfunction

    always_comb begin
        q_d      = q_q;
        prot_hit = page_blocked(q_q.bp, commit_page_i);
        arr_ok   = arr_commit_i & q_q.wel & ~q_q.busy & ~prot_hit & (|q_q.mask);
        sr_ok    = sr_commit_i & q_q.wel & ~q_q.busy;

        if (lat_clr_i) q_d.mask = '0;
        if (lat_we_i)  q_d.mask[lat_idx_i] = 1'b1;
        if (wel_set_i) q_d.wel = 1'b1;
        if (wel_clr_i) q_d.wel = 1'b0;
        if (sr_ok)     q_d.bp  = sr_bp_i;

        if (arr_ok || sr_ok) begin
            q_d.wel  = 1'b0;
            q_d.busy = 1'b1;
            q_d.cnt  = CNT_W'(WR_CYCLES - 1);
        end else if (q_q.busy) begin
            if (q_q.cnt == '0) q_d.busy = 1'b0;
            else               q_d.cnt  = q_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    always_ff @(posedge clk) begin
        if (lat_we_i) lat_q[lat_idx_i] <= lat_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= '0;
        end else if (arr_ok) begin
            for (int p = 0; p < PAGE_BYTES; p++)
                if (q_q.mask[p]) mem_q[{commit_page_i, PAGE_W'(p)}] <= lat_q[p];
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];
    assign status_o  = {4'b0000, q_q.bp, q_q.wel, q_q.busy};
    assign busy_o    = q_q.busy;

    a_r7_flag_drops: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_q.busy) |-> !q_q.wel);
    a_r7_busy_ends_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q_q.busy) |-> $past(q_q.cnt) == '0);
    a_r9_blocked_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_commit_i && prot_hit && !q_q.busy) |=> !q_q.busy);
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
    import spimem_pkg::*;
#(
    parameter int WR_CYCLES   = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    input  logic hold_n,
    output logic so,
    output logic so_oe
);
    logic [3:0] pins_s;
    logic [ADDR_W-1:0]     rd_addr;
    logic [7:0]            rd_data, status, lat_data;
    logic                  lat_clr, lat_we, arr_commit, sr_commit, wel_set, wel_clr, busy;
    logic [PAGE_W-1:0]     lat_idx;
    logic [PAGE_NUM_W-1:0] commit_page;
    logic [1:0]            sr_bp;

    // bit order: hold_n, si, cs_n, sck; idle values are high, low, high, low
    spimem_sync #(.N(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1010)) sync_i (
        .clk(clk), .rst_n(rst_n), .din({hold_n, si, cs_n, sck}), .dout(pins_s)
    );

    spimem_seq seq_i (
        .clk(clk), .rst_n(rst_n),
        .sck_s(pins_s[0]), .cs_n_s(pins_s[1]), .si_s(pins_s[2]), .hold_n_s(pins_s[3]),
        .busy_i(busy), .status_i(status), .rd_data_i(rd_data), .rd_addr_o(rd_addr),
        .lat_clr_o(lat_clr), .lat_we_o(lat_we), .lat_idx_o(lat_idx), .lat_data_o(lat_data),
        .arr_commit_o(arr_commit), .commit_page_o(commit_page),
        .sr_commit_o(sr_commit), .sr_bp_o(sr_bp),
        .wel_set_o(wel_set), .wel_clr_o(wel_clr), .so_o(so), .so_oe_o(so_oe)
    );

    spimem_store #(.WR_CYCLES(WR_CYCLES)) store_i (
        .clk(clk), .rst_n(rst_n), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .lat_clr_i(lat_clr), .lat_we_i(lat_we), .lat_idx_i(lat_idx), .lat_data_i(lat_data),
        .arr_commit_i(arr_commit), .commit_page_i(commit_page),
        .sr_commit_i(sr_commit), .sr_bp_i(sr_bp),
        .wel_set_i(wel_set), .wel_clr_i(wel_clr), .status_o(status), .busy_o(busy)
    );
endmodule

// File: tb/serial_mem_slave_tb_top.sv
module serial_mem_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 80;
    localparam int WRC        = 1500;

    logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, si = 0, hold_n = 1;
    logic so, so_oe;
    int checks = 0, errors = 0;
    logic [7:0] exp_mem [512];
    logic [7:0] rx_b, st;
    logic oe_and, oe_or;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_mem_slave #(.WR_CYCLES(WRC)) dut_i (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .hold_n(hold_n), .so(so), .so_oe(so_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_sck();
        sck = 1; #HALF; sck = 0; #HALF;
    endtask

    // hb selects the bit at which HOLD is applied; hi places the fall inside the SCK high phase
    task automatic xfer(input logic [7:0] tx, input int hb, input bit hi);
        rx_b = 0; oe_and = 1; oe_or = 0;
        for (int i = 7; i >= 0; i--) begin
            if (i == hb && !hi) begin
                hold_n = 0; #HALF;
                chk("R10 output released during hold", so_oe, 0);
                si = ~tx[i]; pulse_sck(); pulse_sck();
                hold_n = 1; #HALF;
            end
            si = tx[i]; #HALF;
            rx_b[i] = so; oe_and &= so_oe; oe_or |= so_oe;
            sck = 1;
            if (i == hb && hi) begin
                #(HALF/2); hold_n = 0; #(HALF/2); sck = 0; #HALF;
                chk("R11 output released after late hold", so_oe, 0);
                si = ~si; pulse_sck(); pulse_sck();
                hold_n = 1; #HALF;
            end else begin
                #HALF; sck = 0;
            end
        end
    endtask

    task automatic xfer_bits(input logic [7:0] tx, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            si = tx[i]; #HALF; sck = 1; #HALF; sck = 0;
        end
    endtask

    task automatic sel();   cs_n = 0; #HALF; endtask
    task automatic desel(); #HALF; cs_n = 1; #(3*HALF); endtask

    task automatic rdsr(output logic [7:0] s);
        sel(); xfer(8'h05, -1, 0); xfer(8'h00, -1, 0); s = rx_b; desel();
    endtask

    task automatic cmd1(input logic [7:0] op);
        sel(); xfer(op, -1, 0); desel();
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 60; n++) begin
            rdsr(st);
            if (!st[0]) break;
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'((seed + k * 7) & 255);
    endfunction

    task automatic mem_write(input int addr, input int n, input int seed,
                             input bit ok, input int hb, input bit hi);
        sel();
        xfer({4'b0000, addr[8], 3'b010}, -1, 0);
        xfer(addr[7:0], -1, 0);
        for (int k = 0; k < n; k++) xfer(pat(seed, k), (k == 0) ? hb : -1, hi);
        desel();
        if (ok)
            for (int k = 0; k < n; k++)
                exp_mem[(addr & 9'h1F0) | ((addr + k) & 15)] = pat(seed, k);
    endtask

    task automatic mem_read(input int addr, input int n, input string req,
                            input int hb, input bit hi);
        sel();
        xfer({4'b0000, addr[8], 3'b011}, -1, 0);
        xfer(addr[7:0], -1, 0);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, (k == 1) ? hb : -1, hi);
            chk(req, rx_b, exp_mem[(addr + k) % 512]);
            chk({req, " enable"}, oe_and, 1);
        end
        desel();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 512; i++) exp_mem[i] = 8'h00;
        repeat (5) @(posedge clk);
        rst_n = 1;
        #(4*HALF);

        // R1 reset state
        chk("R1 enable after reset", so_oe, 0);
        rdsr(st); chk("R1 status after reset", st, 8'h00);

        // R4 flag set/clear and repeated status
        cmd1(8'h06);
        sel(); xfer(8'h05, -1, 0); xfer(0, -1, 0); chk("R4 status byte 1", rx_b, 8'h02);
        xfer(0, -1, 0); chk("R4 status byte 2", rx_b, 8'h02); desel();
        chk("R1 enable after deselect", so_oe, 0);
        cmd1(8'h04); rdsr(st); chk("R4 flag cleared", st, 8'h00);

        // R2/R5/R7 full page write at top page, R3 wrap read
        cmd1(8'h06);
        mem_write(9'h1F8, 16, 8'h11, 1, -1, 0);
        rdsr(st); chk("R7 busy and flag cleared", st, 8'h01);
        wait_idle(); chk("R7 busy ends", st, 8'h00);
        mem_read(9'h1F0, 20, "R3 sequential read with wrap", -1, 0);

        // R5 in-page wrap and overwrite
        cmd1(8'h06);
        mem_write(9'h025, 18, 8'h80, 1, -1, 0);
        wait_idle();
        mem_read(9'h020, 16, "R5 page wrap overwrite", -1, 0);

        // R6 abandoned writes
        cmd1(8'h06);
        sel(); xfer(8'h02, -1, 0); xfer(8'h40, -1, 0); xfer(8'hAA, -1, 0); xfer_bits(8'h55, 3); desel();
        rdsr(st); chk("R6 partial byte keeps flag, no busy", st, 8'h02);
        sel(); xfer(8'h02, -1, 0); xfer(8'h40, -1, 0); desel();
        rdsr(st); chk("R6 no data byte, no busy", st, 8'h02);
        mem_read(9'h040, 1, "R6 array unchanged", -1, 0);
        mem_write(9'h040, 1, 8'h33, 1, -1, 0);
        wait_idle();
        mem_read(9'h040, 1, "R6 complete byte commits", -1, 0);

        // R7 no flag, no commit
        mem_write(9'h050, 2, 8'h99, 0, -1, 0);
        rdsr(st); chk("R7 no flag no busy", st, 8'h00);
        mem_read(9'h050, 2, "R7 array unchanged", -1, 0);

        // R8 commands refused while busy
        cmd1(8'h06);
        mem_write(9'h060, 1, 8'h5C, 1, -1, 0);
        sel(); xfer(8'h03, -1, 0); xfer(8'h60, -1, 0); xfer(8'h00, -1, 0);
        chk("R8 read refused while busy", oe_or, 0); desel();
        cmd1(8'h06);
        rdsr(st); chk("R8 status while busy", st, 8'h01);
        wait_idle(); chk("R8 flag set refused while busy", st, 8'h00);
        mem_read(9'h060, 1, "R8 write landed", -1, 0);

        // R9 protection levels
        cmd1(8'h06);
        sel(); xfer(8'h01, -1, 0); xfer(8'h04, -1, 0); desel();
        wait_idle(); chk("R9 level 1 set", st, 8'h04);
        cmd1(8'h06);
        mem_write(9'h185, 1, 8'hE1, 0, -1, 0);
        rdsr(st); chk("R9 level 1 blocks top quarter", st, 8'h06);
        mem_write(9'h175, 1, 8'hE2, 1, -1, 0);
        wait_idle();
        mem_read(9'h180, 8, "R9 top quarter unchanged", -1, 0);
        mem_read(9'h175, 1, "R9 below quarter writable", -1, 0);
        cmd1(8'h06);
        sel(); xfer(8'h01, -1, 0); xfer(8'h08, -1, 0); desel();
        wait_idle(); cmd1(8'h06);
        mem_write(9'h105, 1, 8'hE3, 0, -1, 0);
        rdsr(st); chk("R9 level 2 blocks upper half", st, 8'h0A);
        sel(); xfer(8'h01, -1, 0); xfer(8'h0C, -1, 0); desel();
        wait_idle(); cmd1(8'h06);
        mem_write(9'h005, 1, 8'hE4, 0, -1, 0);
        rdsr(st); chk("R9 level 3 blocks all", st, 8'h0E);
        sel(); xfer(8'h01, -1, 0); xfer(8'h00, -1, 0); desel();
        wait_idle(); chk("R9 level cleared", st, 8'h00);
        mem_read(9'h100, 8, "R9 blocked pages unchanged", -1, 0);
        mem_read(9'h000, 8, "R9 blocked low page unchanged", -1, 0);

        // R10/R11 hold
        mem_read(9'h1F0, 4, "R10 read across hold", 3, 0);
        mem_read(9'h020, 4, "R11 read across late hold", 5, 1);
        cmd1(8'h06);
        mem_write(9'h0A0, 3, 8'h47, 1, 5, 0);
        wait_idle();
        mem_read(9'h0A0, 3, "R10 write across hold", -1, 0);
        cmd1(8'h06);
        mem_write(9'h0B3, 2, 8'h61, 1, 2, 1);
        wait_idle();
        mem_read(9'h0B3, 2, "R11 write across late hold", -1, 0);

        // R12 unknown opcodes
        sel(); xfer(8'hFF, -1, 0); xfer(8'h5A, -1, 0); chk("R12 no drive 1", oe_or, 0);
        xfer(8'h00, -1, 0); chk("R12 no drive 2", oe_or, 0); desel();
        sel(); xfer(8'h0C, -1, 0); xfer(8'h00, -1, 0); chk("R12 no drive 3", oe_or, 0); desel();
        rdsr(st); chk("R12 status unchanged", st, 8'h00);
        mem_read(9'h0A0, 1, "R2 read after unknown opcode", -1, 0);

        finish_run();
    end
endmodule